// File: doc/BRIEF.md
# One-Time-Programmable Area Program Controller

This block takes a serial program command for a 65-byte one-time-programmable area and writes it. Bytes 0 to 63 hold data. Byte 64 is the control byte, and its bit 0 is the lock. Frames arrive one bit at a time on `sdi`, most significant bit first, while `cs_n` is low. Each bit is taken on a rising clock edge where `bit_en` is high. The clock is much faster than the serial bit rate, so the serial link is handled as a bit strobe inside the core clock domain.

A write-enable frame sets the write-enable flag (WEL). A program frame carries an opcode, three address bytes and one or more data bytes. The data bytes are buffered at their target positions. When `cs_n` rises on a byte boundary, a self-timed cycle of `T_PROG` clocks starts and the busy flag (WIP) is raised. At the end of the cycle every buffered byte is merged into the array with a bitwise AND, so a bit can only go from 1 to 0. Once bit 0 of byte 64 reads 0, the array is frozen for good.

`status` gives {WEL, WIP} at all times. `rd_addr`/`rd_data` read the array combinationally.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After reset `status` is 2'b00 and every byte 0..64 reads 8'hFF.
- R2: A frame made only of opcode 8'h06 (8 bits, then `cs_n` rises) sets WEL, which is `status[1]`, when no cycle is running.
- R3: A program frame (opcode 8'h42) sent while WEL is 0 is ignored. WIP stays 0 and the array does not change.
- R4: A program frame is not executed, and WEL stays 1, if `cs_n` rises after a partial byte or before one complete data byte has arrived.
- R5: A valid program frame sets WIP (`status[0]`) on the edge that sees `cs_n` high. WIP stays 1 for exactly `T_PROG` cycles. WEL clears on that same edge.
- R6: When WIP falls, each written byte becomes its old value ANDed with the received data.
- R7: The address bytes are sent most significant first. The first data byte goes to the low 7 bits of the address, and each later byte goes to the next address. Any byte whose target is above 64 is dropped, so at most 65 bytes are stored.
- R8: The lock is bit 0 of byte 64 and is sampled when `cs_n` rises. A command that finds it 0 still runs the cycle and clears WEL, but leaves the array unchanged. A command that clears the lock bit still writes all of its own bytes.
- R9: Frames that start while WIP is 1 are ignored. A write-enable frame sent during a cycle leaves WEL at 0.
- R10: `rd_data` returns the byte at `rd_addr` for addresses 0..64, and 8'hFF for addresses above 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| bit_en | input | 1 | Takes `sdi` on this clock edge |
| sdi | input | 1 | Serial data, most significant bit first |
| rd_addr | input | 7 | Array read address |
| rd_data | output | 8 | Array read data |
| status | output | 2 | {WEL, WIP} |

## Verification
Programs are sent to several start addresses to separate correct placement from placement that is off by one or wraps. These cover a start in mid-array, a start near byte 64, an address with high bits set, a start above 64, and a full 66-byte burst from address 0. A second write over already-cleared bits tests the AND merge: it shows that a 0 is never set back to 1 and that the old value is not simply replaced. Frames are also cut mid-byte or before any data, sent without WEL, and sent during a cycle. This confirms that only a clean frame with WEL set starts the timer. Locking by a command that also writes a data byte shows that the lock is sampled when `cs_n` rises.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t OPC_WR_ENABLE = 8'h06;
  localparam byte_t OPC_OTP_WRITE = 8'h42;
  localparam int    HDR_BYTES     = 4;
endpackage

// File: rtl/otp_bit_rx.sv
module otp_bit_rx #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          bit_en,
  input  logic          sdi,
  output logic          byte_stb,
  output logic [BW-1:0] byte_q,
  output logic          on_boundary
);
  localparam int CW = $clog2(BW);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-2:0] sh_q, sh_d;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (cs_n) begin
      cnt_d = '0;
    end else if (bit_en) begin
      cnt_d = cnt_q + CW'(1);
      sh_d  = {sh_q[BW-3:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign byte_stb    = !cs_n && bit_en && (cnt_q == CW'(BW-1));
  assign byte_q      = {sh_q, sdi};
  assign on_boundary = (cnt_q == '0);
endmodule

// File: rtl/otp_stage_buf.sv
module otp_stage_buf #(
  parameter int N  = 65,
  parameter int AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  output logic [N-1:0][7:0] st_data,
  output logic [N-1:0]      st_mask
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic       hit;
    logic       m_d;
    logic [7:0] d_d;

    assign hit = wr_en && (wr_addr == AW'(i));

    always_comb begin
      m_d = st_mask[i];
      d_d = st_data[i];
      if (clr) begin
        m_d = 1'b0;
      end else if (hit) begin
        m_d = 1'b1;
        d_d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_mask[i] <= 1'b0;
        st_data[i] <= 8'h00;
      end else begin
        st_mask[i] <= m_d;
        st_data[i] <= d_d;
      end
    end
  end
endmodule

// File: rtl/otp_cycle_timer.sv
module otp_cycle_timer #(
  parameter int T_PROG = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(T_PROG + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_d;

  assign done = busy && (cnt_q == CW'(1));

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    if (start && !busy) begin
      cnt_d  = CW'(T_PROG);
      busy_d = 1'b1;
    end else if (busy) begin
      cnt_d = cnt_q - CW'(1);
      if (done) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
    end
  end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int N  = 65,
  parameter int AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [N-1:0][7:0] st_data,
  input  logic [N-1:0]      st_mask,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data,
  output logic              unlocked
);
  logic [7:0] mem [N];

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic [7:0] nx;
    always_comb begin
      nx = mem[i];
      if (commit && st_mask[i]) nx = mem[i] & st_data[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[i] <= 8'hFF;
      else        mem[i] <= nx;
    end
  end

  assign rd_data  = (rd_addr < AW'(N)) ? mem[rd_addr] : 8'hFF;
  assign unlocked = mem[N-1][0];
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl #(
  parameter int T_PROG    = 64,
  parameter int OTP_BYTES = 65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       bit_en,
  input  logic       sdi,
  input  logic [6:0] rd_addr,
  output logic [7:0] rd_data,
  output logic [1:0] status
);
  import otp_pkg::*;

  localparam int AW = $clog2(OTP_BYTES);
  localparam logic [2:0]  NB_SAT  = 3'(HDR_BYTES + 1);
  localparam logic [2:0]  NB_ADDR = 3'(HDR_BYTES - 1);
  localparam logic [AW:0] PTR_LIM = (AW+1)'(OTP_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic        byte_stb, on_boundary;
  byte_t       byte_q;
  logic        busy, done, unlocked;
  logic [OTP_BYTES-1:0][7:0] st_data;
  logic [OTP_BYTES-1:0]      st_mask;

  logic        cs_q, frame_ok_q, wel_q, wr_ok_q;
  logic [2:0]  nbytes_q;
  byte_t       opc_q;
  logic [AW:0] wptr_q;

  logic        frame_ok_d, wel_d, wr_ok_d;
  logic [2:0]  nbytes_d;
  byte_t       opc_d;
  logic [AW:0] wptr_d;

  logic cs_fall, cs_rise, take, accept, wren_ok, prog_ok, data_byte, buf_wr, buf_clr, commit;

  otp_bit_rx #(.BW(8)) u_rx (
    .clk(clk), .rst_n(rst_sync_n), .cs_n(cs_n), .bit_en(bit_en), .sdi(sdi),
    .byte_stb(byte_stb), .byte_q(byte_q), .on_boundary(on_boundary)
  );

  assign cs_fall   = cs_q && !cs_n;
  assign cs_rise   = !cs_q && cs_n;
  assign take      = byte_stb && frame_ok_q;
  assign data_byte = take && (nbytes_q >= 3'(HDR_BYTES));
  assign buf_wr    = data_byte && (opc_q == OPC_OTP_WRITE) && (wptr_q < PTR_LIM);
  assign buf_clr   = cs_fall && !busy;
  assign accept    = cs_rise && frame_ok_q && on_boundary && !busy;
  assign wren_ok   = accept && (opc_q == OPC_WR_ENABLE) && (nbytes_q == 3'd1);
  assign prog_ok   = accept && (opc_q == OPC_OTP_WRITE) && (nbytes_q == NB_SAT) && wel_q;
  assign commit    = done && wr_ok_q;

  always_comb begin
    frame_ok_d = frame_ok_q;
    nbytes_d   = nbytes_q;
    opc_d      = opc_q;
    wptr_d     = wptr_q;
    wel_d      = wel_q;
    wr_ok_d    = wr_ok_q;
    if (cs_fall) begin
      frame_ok_d = !busy;
      nbytes_d   = '0;
    end else if (cs_rise) begin
      frame_ok_d = 1'b0;
    end
    if (take) begin
      if (nbytes_q != NB_SAT) nbytes_d = nbytes_q + 3'd1;
      if (nbytes_q == 3'd0) opc_d = byte_q;
      if (nbytes_q == NB_ADDR) wptr_d = {1'b0, byte_q[AW-1:0]};
      if (data_byte && (wptr_q != '1)) wptr_d = wptr_q + (AW+1)'(1);
    end
    if (prog_ok) begin
      wel_d   = 1'b0;
      wr_ok_d = unlocked;
    end else if (wren_ok) begin
      wel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cs_q       <= 1'b1;
      frame_ok_q <= 1'b0;
      nbytes_q   <= '0;
      opc_q      <= '0;
      wptr_q     <= '0;
      wel_q      <= 1'b0;
      wr_ok_q    <= 1'b0;
    end else begin
      cs_q       <= cs_n;
      frame_ok_q <= frame_ok_d;
      nbytes_q   <= nbytes_d;
      opc_q      <= opc_d;
      wptr_q     <= wptr_d;
      wel_q      <= wel_d;
      wr_ok_q    <= wr_ok_d;
    end
  end

  otp_stage_buf #(.N(OTP_BYTES), .AW(AW)) u_buf (
    .clk(clk), .rst_n(rst_sync_n), .clr(buf_clr), .wr_en(buf_wr),
    .wr_addr(wptr_q[AW-1:0]), .wr_data(byte_q), .st_data(st_data), .st_mask(st_mask)
  );

  otp_cycle_timer #(.T_PROG(T_PROG)) u_tmr (
    .clk(clk), .rst_n(rst_sync_n), .start(prog_ok), .busy(busy), .done(done)
  );

  otp_cell_array #(.N(OTP_BYTES), .AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_sync_n), .commit(commit), .st_data(st_data), .st_mask(st_mask),
    .rd_addr(rd_addr[AW-1:0]), .rd_data(rd_data), .unlocked(unlocked)
  );

  assign status = {wel_q, busy};
endmodule

// File: rtl/otp_prog_chk.sv
module otp_prog_chk (
  input logic clk,
  input logic rst_n,
  input logic wip,
  input logic wel,
  input logic unlocked,
  input logic commit
);
  // R5: WEL is already low on the first busy cycle
  p_wel_clear_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> !wel);

  // R3: a cycle only starts when WEL was set
  p_start_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel));

  // R9: WEL cannot be set while a cycle runs
  p_no_wel_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && !wel) |=> !wel);

  // R8: once locked, the lock never clears
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> !unlocked);

  // R6: the merge happens only in the last busy cycle
  p_commit_ends_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> wip ##1 !wip);
endmodule

bind otp_prog_ctrl otp_prog_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wip(busy), .wel(wel_q),
  .unlocked(unlocked), .commit(commit)
);

// File: tb/sim_otp_prog_ctrl.sv
module sim_otp_prog_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TP = 40;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, bit_en, sdi;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  logic [1:0] status;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_mem [0:64];
  logic [7:0] payload [0:69];

  otp_prog_ctrl #(.T_PROG(TP)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_en(bit_en), .sdi(sdi),
    .rd_addr(rd_addr), .rd_data(rd_data), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic check_array(input string req);
    int bad_i = -1;
    logic [7:0] bad_v = '0;
    for (int i = 0; i < 65; i++) begin
      rd_addr = 7'(i);
      #1;
      if (rd_data !== exp_mem[i] && bad_i < 0) begin
        bad_i = i; bad_v = rd_data;
      end
    end
    if (bad_i < 0) chk(1'b1, req, "array", 0, 0);
    else chk(1'b0, req, $sformatf("array byte %0d", bad_i), bad_v, exp_mem[bad_i]);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdi = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) send_bit(b[k]);
  endtask

  // sends a frame, then samples at the first negedge after cs_n rises
  task automatic frame(input logic [7:0] op, input bit with_addr, input logic [23:0] addr,
                       input int n, input int extra_bits);
    @(negedge clk); cs_n = 1'b0;
    send_byte(op);
    if (with_addr) begin
      send_byte(addr[23:16]); send_byte(addr[15:8]); send_byte(addr[7:0]);
    end
    for (int k = 0; k < n; k++) send_byte(payload[k]);
    for (int k = 0; k < extra_bits; k++) send_bit(1'b1);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (status[0] && cycles < 10000) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic model_prog(input logic [23:0] addr, input int n);
    bit ok = exp_mem[64][0];
    for (int k = 0; k < n; k++) begin
      int a = int'(addr[6:0]) + k;
      if (ok && a <= 64) exp_mem[a] = exp_mem[a] & payload[k];
    end
  endtask

  task automatic wren(input string req);
    frame(8'h06, 0, 24'h0, 0, 0);
    chk(status == 2'b10, req, "WEL set by write-enable", status, 2'b10);
  endtask

  task automatic prog_full(input logic [23:0] addr, input int n, input string req);
    int cyc;
    frame(8'h42, 1, addr, n, 0);
    chk(status == 2'b01, "R5", "status at cycle start", status, 2'b01);
    wait_idle(cyc);
    chk(cyc == TP, "R5", "WIP length", cyc, TP);
    model_prog(addr, n);
    check_array(req);
  endtask

  task automatic t_reset;
    chk(status == 2'b00, "R1", "status after reset", status, 0);
    check_array("R1");
    rd_addr = 7'd100; #1;
    chk(rd_data == 8'hFF, "R10", "read above 64", rd_data, 8'hFF);
    rd_addr = 7'd127; #1;
    chk(rd_data == 8'hFF, "R10", "read 127", rd_data, 8'hFF);
  endtask

  task automatic t_no_wel;
    payload[0] = 8'h00;
    frame(8'h42, 1, 24'h000002, 1, 0);
    chk(status == 2'b00, "R3", "no cycle without WEL", status, 0);
    repeat (5) @(negedge clk);
    chk(status == 2'b00, "R3", "still idle", status, 0);
    check_array("R3");
  endtask

  task automatic t_bad_end;
    wren("R2");
    payload[0] = 8'h00;
    frame(8'h42, 1, 24'h000014, 1, 3);
    chk(status == 2'b10, "R4", "partial-byte end not executed", status, 2'b10);
    frame(8'h42, 1, 24'h000014, 0, 0);
    chk(status == 2'b10, "R4", "no data byte not executed", status, 2'b10);
    repeat (3) @(negedge clk);
    chk(status == 2'b10, "R4", "still idle with WEL", status, 2'b10);
    check_array("R4");
  endtask

  task automatic t_basic_and;
    payload[0] = 8'hA5; payload[1] = 8'h3C;
    prog_full(24'h000005, 2, "R6");
    wren("R2");
    payload[0] = 8'h0F; payload[1] = 8'hC3;
    prog_full(24'h000005, 2, "R6");
    rd_addr = 7'd5; #1;
    chk(rd_data == 8'h05, "R6", "AND merge byte 5", rd_data, 8'h05);
  endtask

  task automatic t_range;
    wren("R7");
    payload[0] = 8'hE7; payload[1] = 8'h7E; payload[2] = 8'hF1;
    payload[3] = 8'h00; payload[4] = 8'h00;
    prog_full(24'h00003E, 5, "R7");
    wren("R7");
    payload[0] = 8'h99;
    prog_full(24'h120083, 1, "R7");
    rd_addr = 7'd3; #1;
    chk(rd_data == 8'h99, "R7", "low 7 address bits", rd_data, 8'h99);
    wren("R7");
    payload[0] = 8'h00;
    prog_full(24'h000046, 1, "R7");
  endtask

  task automatic t_max65;
    wren("R7");
    for (int k = 0; k < 66; k++) payload[k] = 8'hFF ^ 8'(k << 1);
    prog_full(24'h000000, 66, "R7");
  endtask

  task automatic t_busy;
    int cyc;
    wren("R9");
    payload[0] = 8'h77;
    frame(8'h42, 1, 24'h00000A, 1, 0);
    chk(status == 2'b01, "R9", "cycle running", status, 2'b01);
    frame(8'h06, 0, 24'h0, 0, 0);
    chk(status == 2'b01, "R9", "write-enable ignored while busy", status, 2'b01);
    wait_idle(cyc);
    chk(status == 2'b00, "R9", "WEL still clear after cycle", status, 0);
    model_prog(24'h00000A, 1);
    check_array("R9");
  endtask

  task automatic t_lock;
    wren("R8");
    payload[0] = 8'h00; payload[1] = 8'hFE;
    prog_full(24'h00003F, 2, "R8");
    rd_addr = 7'd63; #1;
    chk(rd_data == 8'h00, "R8", "locking command writes its data", rd_data, 0);
    wren("R8");
    payload[0] = 8'h00;
    prog_full(24'h000000, 1, "R8");
    chk(status == 2'b00, "R8", "locked command clears WEL", status, 0);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; bit_en = 1'b0; sdi = 1'b0; rd_addr = '0;
    for (int i = 0; i < 65; i++) exp_mem[i] = 8'hFF;
    for (int i = 0; i < 70; i++) payload[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_no_wel();
    t_bad_end();
    t_basic_and();
    t_range();
    t_max65();
    t_busy();
    t_lock();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule